// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous DRAM refreshed inside each refresh period. An interval timer, counted in clocks from a clock-frequency parameter, marks one refresh as owed every period divided by the row count. The owed count saturates at a small limit, so the access controller can put refresh off during busy stretches and then let the owed cycles run back to back.

Refresh takes the strobes through a request/grant handshake. When at least one refresh is owed and no refresh cycle is running, the block raises its request. The access controller answers with a grant once the memory is idle. The scheduler then drives the strobes for one full refresh cycle, including the precharge, and hands them back. When the owed count reaches its limit the block raises an urgent flag, and the controller must serve refresh before any new access.

The default mode puts CAS low ahead of RAS, so the memory takes the row address from its own refresh counter. A parameter selects a RAS-only mode instead. In that mode the block keeps its own row counter and presents the row while RAS is low, and CAS stays high.

Top module: `dram_refresh_sched`

## Requirements
- R1: The block adds one owed refresh every INTERVAL = (CLK_HZ/1e6)*PERIOD_US/ROWS clocks. The first one shows on `owed_cnt` exactly INTERVAL rising edges after reset is released.
- R2: `owed_cnt` saturates at OWED_MAX. An interval that ends while the count is at OWED_MAX adds nothing.
- R3: `ref_urgent` is 1 exactly when `owed_cnt` equals OWED_MAX.
- R4: `ref_req` is 1 exactly when no refresh cycle is running and `owed_cnt` is non-zero. A clock edge that sees `ref_req` and `ref_gnt` both at 1 starts a cycle, and `ref_busy` is 1 after that edge.
- R5: In CAS-before-RAS mode, both CAS strobes go low for T_SETUP clocks while RAS is still high. They stay low for the whole time RAS is low.
- R6: RAS stays low for exactly T_RAS clocks. After that, all strobes stay high for T_RP clocks before `ref_busy` falls, and no other cycle starts during that time.
- R7: `we_n` is 1 at all times, in both modes.
- R8: A finished cycle lowers `owed_cnt` by one. If a cycle finishes on the same edge that an interval ends, `owed_cnt` stays the same.
- R9: In RAS-only mode both CAS strobes stay high. `row_addr` does not change while RAS is low. The row goes up by one after each refresh and wraps from ROWS-1 to 0. In CAS-before-RAS mode `row_addr` is 0.
- R10: While reset is held, all strobes are high, `owed_cnt` is 0, and `ref_req`, `ref_urgent` and `ref_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request |
| ref_urgent | output | 1 | Owed count is at its limit |
| ref_busy | output | 1 | The scheduler is driving the strobes |
| owed_cnt | output | $clog2(OWED_MAX+1) | Number of refreshes owed |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | $clog2(ROWS) | Row address for RAS-only refresh |

## Verification
Three situations are hard to reach from the ports:
- An interval that ends on the same clock as a cycle finishing.
- An interval that ends while the owed count is already at its limit.
- The row counter wrapping, which needs more than a thousand refreshes.

The stimulus withholds the grant for long windows, so the count saturates and is then drained in bursts. Between these windows the grant is given with a random probability, which makes interval ends land on every phase of a running cycle. A second instance in RAS-only mode runs with a very short interval, so its row counter wraps within the run.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_PRECHG = 2'd3
    } ref_phase_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(INTERVAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = (tmr_q.cnt == CW'(INTERVAL - 1));
        if (tick_o) tmr_d.cnt = '0;
        else        tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R1: interval ends are never back to back
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ref_owed_counter.sv
module ref_owed_counter #(
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          done_i,
    output logic [OW-1:0] owed_o
);
    typedef struct packed {
        logic [OW-1:0] owed;
    } owe_reg_t;

    owe_reg_t owe_d, owe_q;

    always_comb begin
        owe_d = owe_q;
        if (tick_i && !done_i) begin
            if (owe_q.owed != OW'(OWED_MAX)) owe_d.owed = owe_q.owed + 1'b1;
        end else if (done_i && !tick_i) begin
            owe_d.owed = owe_q.owed - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owe_q <= '0;
        else        owe_q <= owe_d;
    end

    assign owed_o = owe_q.owed;

    p_owed_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        owed_o <= OW'(OWED_MAX));

    p_owed_balance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && done_i) |=> $stable(owed_o));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (owed_o != '0));
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
    import refresh_pkg::*;
#(
    parameter int unsigned T_SETUP  = 2,
    parameter int unsigned T_RAS    = 6,
    parameter int unsigned T_RP     = 5,
    parameter int unsigned ROWS     = 1024,
    parameter bit          RAS_ONLY = 1'b0,
    localparam int unsigned RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          idle_o,
    output logic          done_o,
    output logic          ras_n_o,
    output logic          casl_n_o,
    output logic          cash_n_o,
    output logic          we_n_o,
    output logic [RW-1:0] row_o
);
    localparam int unsigned T_A  = (T_SETUP > T_RAS) ? T_SETUP : T_RAS;
    localparam int unsigned T_MX = (T_A > T_RP) ? T_A : T_RP;
    localparam int unsigned CNTW = $clog2(T_MX + 1);

    typedef struct packed {
        ref_phase_e      ph;
        logic [CNTW-1:0] cnt;
        logic [RW-1:0]   row;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        done_o = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph  = PH_SETUP;
                    seq_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == CNTW'(T_SETUP - 1)) begin
                    seq_d.ph  = PH_STROBE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == CNTW'(T_RAS - 1)) begin
                    seq_d.ph  = PH_PRECHG;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_PRECHG: begin
                if (seq_q.cnt == CNTW'(T_RP - 1)) begin
                    done_o   = 1'b1;
                    seq_d.ph = PH_IDLE;
                    if (RAS_ONLY) begin
                        if (seq_q.row == RW'(ROWS - 1)) seq_d.row = '0;
                        else                            seq_d.row = seq_q.row + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, row: '0};
        else        seq_q <= seq_d;
    end

    assign idle_o  = (seq_q.ph == PH_IDLE);
    assign ras_n_o = (seq_q.ph != PH_STROBE);
    assign we_n_o  = 1'b1;
    assign row_o   = seq_q.row;

    generate
        if (RAS_ONLY) begin : g_ras_only
            assign casl_n_o = 1'b1;
            assign cash_n_o = 1'b1;

            p_row_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!ras_n_o && !$rose(ras_n_o)) |=> ($stable(row_o) || ras_n_o));
        end else begin : g_cbr
            assign casl_n_o = !((seq_q.ph == PH_SETUP) || (seq_q.ph == PH_STROBE));
            assign cash_n_o = casl_n_o;

            p_cas_before_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n_o) |-> ($past(!casl_n_o) && $past(!cash_n_o) && !casl_n_o));
        end
    endgenerate

    logic [15:0] low_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_len_q <= '0;
        else if (!ras_n_o) low_len_q <= low_len_q + 1'b1;
        else               low_len_q <= '0;
    end

    p_ras_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_len_q == 16'(T_RAS)));

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> !idle_o);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned PERIOD_US = 16_000,
    parameter int unsigned ROWS      = 1024,
    parameter int unsigned OWED_MAX  = 8,
    parameter int unsigned T_SETUP   = 2,
    parameter int unsigned T_RAS     = 6,
    parameter int unsigned T_RP      = 5,
    parameter bit          RAS_ONLY  = 1'b0,
    localparam int unsigned OW = $clog2(OWED_MAX + 1),
    localparam int unsigned RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_gnt,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          ref_busy,
    output logic [OW-1:0] owed_cnt,
    output logic          ras_n,
    output logic          casl_n,
    output logic          cash_n,
    output logic          we_n,
    output logic [RW-1:0] row_addr
);
    localparam int unsigned INTERVAL = (CLK_HZ / 1_000_000) * PERIOD_US / ROWS;

    logic tick, done, idle, start;

    ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ref_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .done_i (done),
        .owed_o (owed_cnt)
    );

    ref_strobe_seq #(
        .T_SETUP  (T_SETUP),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP),
        .ROWS     (ROWS),
        .RAS_ONLY (RAS_ONLY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .idle_o   (idle),
        .done_o   (done),
        .ras_n_o  (ras_n),
        .casl_n_o (casl_n),
        .cash_n_o (cash_n),
        .we_n_o   (we_n),
        .row_o    (row_addr)
    );

    always_comb begin
        ref_req    = idle && (owed_cnt != '0);
        ref_urgent = (owed_cnt == OW'(OWED_MAX));
        ref_busy   = !idle;
        start      = ref_req && ref_gnt;
    end

    // R4: a request is only raised while idle and something is owed
    p_req_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (!ref_busy && ras_n));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int TSU = 2, TRAS = 6, TRP = 5, OMAX = 8, NROWS = 1024;
    localparam int IV_A = 100 * 16000 / 1024;   // 1562
    localparam int IV_B = 1 * 16000 / 1024;     // 15

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    always #5 clk = ~clk;

    logic       a_req, a_urg, a_busy, a_ras, a_casl, a_cash, a_we;
    logic [3:0] a_owed;
    logic [9:0] a_row;
    logic       b_req, b_urg, b_busy, b_ras, b_casl, b_cash, b_we;
    logic [3:0] b_owed;
    logic [9:0] b_row;

    dram_refresh_sched #(.CLK_HZ(100_000_000), .PERIOD_US(16000), .ROWS(NROWS),
        .OWED_MAX(OMAX), .T_SETUP(TSU), .T_RAS(TRAS), .T_RP(TRP), .RAS_ONLY(1'b0))
    i_dram_refresh_sched (.clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(a_req),
        .ref_urgent(a_urg), .ref_busy(a_busy), .owed_cnt(a_owed), .ras_n(a_ras),
        .casl_n(a_casl), .cash_n(a_cash), .we_n(a_we), .row_addr(a_row));

    dram_refresh_sched #(.CLK_HZ(1_000_000), .PERIOD_US(16000), .ROWS(NROWS),
        .OWED_MAX(OMAX), .T_SETUP(TSU), .T_RAS(TRAS), .T_RP(TRP), .RAS_ONLY(1'b1))
    i_dram_refresh_sched_ro (.clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(b_req),
        .ref_urgent(b_urg), .ref_busy(b_busy), .owed_cnt(b_owed), .ras_n(b_ras),
        .casl_n(b_casl), .cash_n(b_cash), .we_n(b_we), .row_addr(b_row));

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    typedef struct { int t; int owed; int ph; int c; int row; } mdl_t;
    mdl_t ma, mb;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic mdl_t step(mdl_t m, bit g, int iv);
        mdl_t n = m;
        bit tick  = (m.t == iv - 1);
        bit done  = (m.ph == 3) && (m.c == TRP - 1);
        bit start = (m.ph == 0) && (m.owed != 0) && g;
        n.t = tick ? 0 : m.t + 1;
        if (tick && !done) n.owed = (m.owed == OMAX) ? m.owed : m.owed + 1;
        else if (done && !tick) n.owed = m.owed - 1;
        case (m.ph)
            0: if (start) begin n.ph = 1; n.c = 0; end
            1: if (m.c == TSU - 1) begin n.ph = 2; n.c = 0; end else n.c = m.c + 1;
            2: if (m.c == TRAS - 1) begin n.ph = 3; n.c = 0; end else n.c = m.c + 1;
            default: if (done) begin n.ph = 0; n.row = (m.row + 1) % NROWS; end
                     else n.c = m.c + 1;
        endcase
        return n;
    endfunction

    int prev_brow = 0;
    bit saw_wrap = 1'b0;

    task automatic compare();
        // CBR instance
        chk("R1/R2/R8", "owed A", int'(a_owed), ma.owed);
        chk("R3", "urgent A", int'(a_urg), int'(ma.owed == OMAX));
        chk("R4", "req A", int'(a_req), int'(ma.ph == 0 && ma.owed != 0));
        chk("R4", "busy A", int'(a_busy), int'(ma.ph != 0));
        chk("R6", "ras A", int'(a_ras), int'(ma.ph != 2));
        chk("R5", "casl A", int'(a_casl), int'(!(ma.ph == 1 || ma.ph == 2)));
        chk("R5", "cash A", int'(a_cash), int'(!(ma.ph == 1 || ma.ph == 2)));
        chk("R7", "we A", int'(a_we), 1);
        chk("R9", "row A (CBR zero)", int'(a_row), 0);
        // RAS-only instance
        chk("R1/R2/R8", "owed B", int'(b_owed), mb.owed);
        chk("R4", "req B", int'(b_req), int'(mb.ph == 0 && mb.owed != 0));
        chk("R6", "ras B", int'(b_ras), int'(mb.ph != 2));
        chk("R9", "cas B high", int'(b_casl & b_cash), 1);
        chk("R7", "we B", int'(b_we), 1);
        chk("R9", "row B", int'(b_row), mb.row);
        if (prev_brow == NROWS - 1 && int'(b_row) == 0) saw_wrap = 1'b1;
        prev_brow = int'(b_row);
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            ma = step(ma, gnt, IV_A);
            mb = step(mb, gnt, IV_B);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        #(190000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd31337));
        ma = '{default: 0};
        mb = '{default: 0};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "ras", int'(a_ras & b_ras), 1);
        chk("R10", "cas", int'(a_casl & a_cash & b_casl & b_cash), 1);
        chk("R10", "owed", int'(a_owed) + int'(b_owed), 0);
        chk("R10", "req/urg/busy", int'(a_req | a_urg | a_busy | b_req | b_busy), 0);
        rst_n = 1'b1;

        // R1: first owed refresh exactly one interval after release
        cyc(IV_A - 1);
        chk("R1", "owed one edge early", int'(a_owed), 0);
        cyc(1);
        chk("R1", "owed at interval", int'(a_owed), 1);

        // R2/R3: withhold grant until saturation
        cyc(9 * IV_A);
        chk("R2", "saturated owed", int'(a_owed), OMAX);
        chk("R3", "urgent at limit", int'(a_urg), 1);

        // burst drain
        gnt = 1'b1;
        cyc(400);
        chk("R8", "drained after burst", int'(a_owed), 0);

        // random grant patterns
        for (int blk = 0; blk < 40; blk++) begin
            int pct;
            case ($urandom_range(3))
                0: pct = 0;
                1: pct = 15;
                2: pct = 60;
                default: pct = 100;
            endcase
            for (int k = 0; k < 1500; k++) begin
                gnt = ($urandom_range(99) < pct);
                cyc(1);
            end
        end
        chk("R9", "row counter wrapped 1023->0", int'(saw_wrap), 1);

        summary();
        $finish;
    end
endmodule